// File: doc/BRIEF.md
# Handshaked PHY Register Target

This block is the PHY-side end of an indirect register port. A requester reaches a small bank of 16-bit configuration and status registers through one 20-bit control word and reads back a 17-bit status word. The control word has a 16-bit value bus and four strobes. Two strobes load the register address and the pending write data from that bus. The other two commit a write or start a read. Every strobe is answered with a four-phase handshake: the strobe rises, the acknowledge rises, the strobe falls, then the acknowledge falls.

The acknowledge comes a set number of cycles after the strobe is seen, so a requester's timeout path can be tested against a slow target. Addresses outside the mapped window complete the handshake normally, but they hold no storage. One mapped slot is a fixed status register that reports a valid receive output.

Top module: `phy_reg_target`

## Requirements
- R1: After reset the acknowledge (status bit 16) and read data (status bits 15:0) are zero. Every mapped register reads zero, except the receive-output status register at offset 0xD, which reads 0x0001.
- R2: Control word bits 15:0 carry the value bus. The strobes are capture-address at bit 16, capture-data at bit 17, write at bit 18 and read at bit 19.
- R3: An action starts at the first clock edge where exactly one strobe is high and all strobes were low on the edge before. The acknowledge rises ACK_DELAY cycles after that edge.
- R4: The acknowledge stays high while the started strobe stays high. It falls one cycle after that strobe is seen low.
- R5: A capture-address action latches the bus as the register address. A capture-data action latches the bus as the pending write data. Neither changes any register.
- R6: A write action stores the pending data at the captured address if that address is mapped. A later read returns the stored value.
- R7: A read action returns the addressed register on status bits 15:0 while the acknowledge is high. Those bits read zero at all other times.
- R8: The register at BASE_ADDR+0xD (default 0x100D) always reads 0x0001, with bit 0 meaning the receive output is valid. Writes to it are discarded.
- R9: If more than one strobe is high, no action starts and no acknowledge is given. A strobe left high after the others drop also starts nothing until all strobes have been low.
- R10: An address outside BASE_ADDR to BASE_ADDR+NUM_REGS-1 is still acknowledged. A read there returns zero, and a write there changes no register, including the register whose offset matches the address's low bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_word | input | 20 | Value bus in bits 15:0; strobes in bits 19:16 |
| stat_word | output | 17 | Acknowledge in bit 16; read data in bits 15:0 |

## Verification
Wrong internal state shows up at the ports within one handshake. A bad acknowledge counter or state shifts the cycle in which bit 16 rises or falls, and the bench checks that to the exact cycle on every strobe. Corrupt address, pending-data or register contents show up on the next read handshake as a wrong value in bits 15:0. A wrongly started action from overlapping strobes shows up either as an acknowledge that should never appear or as a later read of the wrong data.

// File: rtl/phy_reg_target.sv
module phy_reg_target #(
  parameter int          NUM_REGS  = 16,
  parameter logic [15:0] BASE_ADDR = 16'h1000,
  parameter int          ACK_DELAY = 3,
  parameter int          STAT_IDX  = 13,
  parameter logic [15:0] STAT_VAL  = 16'h0001
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] ctl_word,
  output logic [16:0] stat_word
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int CNT_W = (ACK_DELAY > 1) ? $clog2(ACK_DELAY) : 1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(ACK_DELAY - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} st_t;

  logic [15:0] bus;
  logic [3:0]  strb;
  assign bus  = ctl_word[15:0];
  assign strb = ctl_word[19:16];

  st_t         st;
  logic [CNT_W-1:0] cnt;
  logic [3:0]  strb_q, op_q;
  logic [15:0] addr_q, pend_q, rd_q;
  logic [15:0] bank [NUM_REGS];

  logic single, start, ack, mapped;
  logic [16:0] off_full;
  logic [IDX_W-1:0] idx;

  assign single   = (strb != 4'd0) && ((strb & (strb - 4'd1)) == 4'd0);
  assign start    = (st == S_IDLE) && single && (strb_q == 4'd0);
  assign ack      = (st == S_HOLD);
  assign off_full = {1'b0, addr_q} - {1'b0, BASE_ADDR};
  assign mapped   = (addr_q >= BASE_ADDR) && (off_full < 17'(NUM_REGS));
  assign idx      = off_full[IDX_W-1:0];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i == STAT_IDX) begin : g_fixed
      assign bank[i] = STAT_VAL;
    end else begin : g_rw
      logic [15:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else if (start && strb[2] && mapped && (idx == IDX_W'(i))) r <= pend_q;
      end
      assign bank[i] = r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      strb_q <= '0;
      op_q   <= '0;
      addr_q <= '0;
      pend_q <= '0;
      rd_q   <= '0;
    end else begin
      strb_q <= strb;
      case (st)
        S_IDLE: if (start) begin
          op_q <= strb;
          cnt  <= CNT_INIT;
          st   <= S_WAIT;
          if (strb[0]) addr_q <= bus;
          if (strb[1]) pend_q <= bus;
          if (strb[3]) rd_q   <= mapped ? bank[idx] : 16'h0000;
        end
        S_WAIT: if (cnt == '0) st <= S_HOLD;
                else cnt <= cnt - 1'b1;
        S_HOLD: if ((strb & op_q) == 4'd0) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign stat_word = {ack, (ack && op_q[3]) ? rd_q : 16'h0000};

  a_r9_no_start_on_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && $countones(strb) > 1) |=> (st == S_IDLE));

  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (strb & op_q) != 4'd0) |=> ack);

  a_r4_ack_released: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (strb & op_q) == 4'd0) |=> !ack);

  a_r5_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (start && strb[0]) |=> (addr_q == $past(bus)));

  a_r3_ack_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(st) == S_WAIT));

  a_r3_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT) |-> (cnt <= CNT_INIT));
endmodule

// File: tb/sim_phy_reg_target.sv
module sim_phy_reg_target;
  localparam int D = 3;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [19:0] ctl = '0;
  logic [16:0] stat;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [15:0] mdl [16];

  always #10 clk = ~clk;

  phy_reg_target #(.ACK_DELAY(D)) u0 (.clk(clk), .rst_n(rst_n), .ctl_word(ctl), .stat_word(stat));

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_val(logic [15:0] a);
    if (a < 16'h1000 || a > 16'h100F) return 16'h0000;
    if (a[3:0] == 4'hD) return 16'h0001;
    return mdl[a[3:0]];
  endfunction

  task automatic strobe(int b, logic [15:0] v, output logic [15:0] rd);
    int n = 0;
    @(negedge clk);
    ctl = {4'b0, v} | (20'h1 << (16 + b));
    do begin
      @(negedge clk);
      n++;
    end while (!stat[16] && n < 40);
    chk(n == D + 1, "R3 ack latency", n, D + 1);
    rd = stat[15:0];
    @(negedge clk);
    chk(stat[16] == 1'b1, "R4 ack held", stat[16], 1);
    ctl = {4'b0, v};
    @(negedge clk);
    chk(stat == 17'h0, "R4/R7 ack and data released", stat, 0);
  endtask

  task automatic wr(logic [15:0] a, logic [15:0] d);
    logic [15:0] x;
    strobe(0, a, x);
    strobe(1, d, x);
    strobe(2, 16'h0, x);
    if (a >= 16'h1000 && a <= 16'h100F && a[3:0] != 4'hD) mdl[a[3:0]] = d;
  endtask

  task automatic rd_chk(logic [15:0] a, string req);
    logic [15:0] x;
    strobe(0, a, x);
    strobe(3, 16'hA5A5, x);
    chk(x == exp_val(a), req, x, exp_val(a));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    chk(stat == 17'h0, "R1 reset status", stat, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stat == 17'h0, "R1 status after reset", stat, 0);
    for (int i = 0; i < 16; i++) rd_chk(16'h1000 + 16'(i), "R1 reset register value");

    wr(16'h1005, 16'h0028);
    rd_chk(16'h1005, "R6 write then read 0x1005");
    wr(16'h100F, 16'hFFFF);
    rd_chk(16'h100F, "R6 top mapped register");
    wr(16'h100D, 16'h0000);
    rd_chk(16'h100D, "R8 status register fixed");
    wr(16'h2005, 16'hBEEF);
    rd_chk(16'h1005, "R10 aliased write discarded");
    rd_chk(16'h2005, "R10 unmapped read zero");
    wr(16'h0FFF, 16'h1111);
    rd_chk(16'h0FFF, "R10 below window read zero");

    begin
      logic [15:0] x;
      strobe(0, 16'h1003, x);
      strobe(1, 16'h1234, x);
      @(negedge clk);
      ctl = 20'h3_1006;
      repeat (8) @(negedge clk);
      chk(stat[16] == 1'b0, "R9 overlap no ack", stat[16], 0);
      ctl = 20'h2_5555;
      repeat (8) @(negedge clk);
      chk(stat[16] == 1'b0, "R9 leftover strobe no ack", stat[16], 0);
      ctl = 20'h0;
      repeat (2) @(negedge clk);
      strobe(2, 16'h0, x);
      mdl[3] = 16'h1234;
      rd_chk(16'h1003, "R5 R9 captures kept through overlap");
      rd_chk(16'h1006, "R9 overlap wrote nothing");
    end

    for (int k = 0; k < 150; k++) begin
      logic [15:0] a;
      a = ($urandom % 5 == 0) ? 16'($urandom) : 16'h1000 + 16'($urandom % 16);
      if ($urandom % 2) wr(a, 16'($urandom));
      else rd_chk(a, "R6 R2 random access");
    end

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule